// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block picks, for each of the two ALU operands of an in-order five-stage pipeline, where the operand comes from. The operand can be read from the register file. It can instead be bypassed from the result waiting in the execute/memory stage register, or from the value about to be written back out of the memory/write-back stage register. The selection compares the two source register numbers of the instruction now in execute against the destination number and write-enable bit of each of the two older instructions.

A forward is made only when the older instruction will actually write a register, and never for register zero. When both older instructions target the same source register, the newer one (the execute/memory stage) wins, because its result is the most recent. The wrapper also contains the two operand multiplexors. It therefore returns both the 2-bit select codes and the chosen operand words. The whole block is combinational.

Top module: `fwd_bypass_unit`

## Requirements
- R1: When neither later stage qualifies for an operand, its select is 2'b00 and the operand equals the register-file word.
- R2: When the execute/memory stage has its write enable high, a nonzero destination, and a destination equal to the operand's source number, the select is 2'b10 and the operand equals the execute/memory result.
- R3: When only the memory/write-back stage qualifies in the same way, the select is 2'b01 and the operand equals the write-back value.
- R4: When both stages qualify for the same operand, the execute/memory stage wins: select 2'b10 with the execute/memory result.
- R5: A destination number of 0 never causes a forward from either stage, even with its write enable high.
- R6: A stage whose write enable is low never forwards. If the execute/memory stage matches but its write enable is low, a qualifying write-back stage still forwards (2'b01).
- R7: Operand A is matched only against the rs number and operand B only against the rt number. The two selections are independent of each other.
- R8: The selects and operands follow the inputs within the same cycle, with no clock and no stored state.
- R9: The select code 2'b11 is never produced.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_src_rs | input | 5 | First source register number of the instruction in execute |
| ex_src_rt | input | 5 | Second source register number of the instruction in execute |
| exm_dst | input | 5 | Destination number held in the execute/memory stage register |
| exm_wen | input | 1 | Register write enable of the execute/memory stage |
| wbk_dst | input | 5 | Destination number held in the memory/write-back stage register |
| wbk_wen | input | 1 | Register write enable of the memory/write-back stage |
| rf_word_a | input | 32 | Register-file word for operand A |
| rf_word_b | input | 32 | Register-file word for operand B |
| exm_result | input | 32 | Result waiting in the execute/memory stage register |
| wbk_value | input | 32 | Value being written back from the memory/write-back stage |
| sel_a | output | 2 | Source select for operand A (00 file, 10 exe/mem, 01 write-back) |
| sel_b | output | 2 | Source select for operand B |
| opnd_a | output | 32 | Selected operand A |
| opnd_b | output | 32 | Selected operand B |

## Verification
Every result of this block is due zero cycles after its stimulus, because both the selects and the operands are pure functions of the current inputs. The bench changes its inputs one nanosecond after a rising edge. It compares all four outputs against its reference model at the following falling edge, so the inputs have settled and no clock edge lies between the stimulus and the sample. The register-file, execute/memory and write-back words all carry different patterns, so a wrong operand shows which source it came from.

// File: rtl/fwd_pkg.sv
package fwd_pkg;

   typedef enum logic [1:0] {
      FWD_RF  = 2'b00,
      FWD_WBK = 2'b01,
      FWD_EXM = 2'b10
   } fwd_sel_e;

   localparam int unsigned FWD_STAGES = 2;
   localparam int unsigned FWD_OPNDS  = 2;

endpackage

// File: rtl/fwd_hit_cmp.sv
module fwd_hit_cmp #(
   parameter int unsigned REG_W     = 5,
   parameter bit          EXCL_ZERO = 1'b1
) (
   input  logic [REG_W-1:0] src_num,
   input  logic [REG_W-1:0] dst_num,
   input  logic             dst_wen,
   output logic             hit
);

   generate
      if (REG_W < 1) begin : g_bad_width
         $error("fwd_hit_cmp: REG_W must be at least 1");
      end
   endgenerate

   logic same_num;
   logic dst_live;

   assign same_num = (src_num == dst_num);

   generate
      if (EXCL_ZERO) begin : g_zero_excluded
         assign dst_live = dst_wen && (dst_num != '0);
      end else begin : g_zero_allowed
         assign dst_live = dst_wen;
      end
   endgenerate

   always_comb begin
      hit = same_num && dst_live;
      // R6
      no_wen_hit_chk: assert (!(hit && !dst_wen));
      // R5
      zero_dst_hit_chk: assert (!(EXCL_ZERO && hit && dst_num == '0));
   end

endmodule

// File: rtl/fwd_sel_arb.sv
module fwd_sel_arb
   import fwd_pkg::*;
(
   input  logic     exm_hit,
   input  logic     wbk_hit,
   output fwd_sel_e sel
);

   always_comb begin
      if (exm_hit)
         sel = FWD_EXM;
      else if (wbk_hit)
         sel = FWD_WBK;
      else
         sel = FWD_RF;
      // R4
      exm_priority_chk: assert (!(exm_hit && sel != FWD_EXM));
      // R1
      idle_file_chk: assert (exm_hit || wbk_hit || sel == FWD_RF);
      // R9
      no_code3_chk: assert (sel != fwd_sel_e'(2'b11));
   end

endmodule

// File: rtl/fwd_opnd_mux.sv
module fwd_opnd_mux
   import fwd_pkg::*;
#(
   parameter int unsigned DATA_W = 32
) (
   input  fwd_sel_e          sel,
   input  logic [DATA_W-1:0] rf_word,
   input  logic [DATA_W-1:0] exm_word,
   input  logic [DATA_W-1:0] wbk_word,
   output logic [DATA_W-1:0] y
);

   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("fwd_opnd_mux: DATA_W must be at least 1");
      end
   endgenerate

   always_comb begin
      unique case (sel)
         FWD_EXM: y = exm_word;
         FWD_WBK: y = wbk_word;
         default: y = rf_word;
      endcase
      // R2
      mux_exm_chk: assert (sel != FWD_EXM || y == exm_word);
      // R3
      mux_wbk_chk: assert (sel != FWD_WBK || y == wbk_word);
   end

endmodule

// File: rtl/fwd_bypass_unit.sv
module fwd_bypass_unit
   import fwd_pkg::*;
#(
   parameter int unsigned REG_W     = 5,
   parameter int unsigned DATA_W    = 32,
   parameter bit          EXCL_ZERO = 1'b1
) (
   input  logic [REG_W-1:0]  ex_src_rs,
   input  logic [REG_W-1:0]  ex_src_rt,
   input  logic [REG_W-1:0]  exm_dst,
   input  logic              exm_wen,
   input  logic [REG_W-1:0]  wbk_dst,
   input  logic              wbk_wen,
   input  logic [DATA_W-1:0] rf_word_a,
   input  logic [DATA_W-1:0] rf_word_b,
   input  logic [DATA_W-1:0] exm_result,
   input  logic [DATA_W-1:0] wbk_value,
   output logic [1:0]        sel_a,
   output logic [1:0]        sel_b,
   output logic [DATA_W-1:0] opnd_a,
   output logic [DATA_W-1:0] opnd_b
);

   localparam int unsigned NOP = FWD_OPNDS;

   generate
      if (REG_W > 16) begin : g_bad_reg_w
         $error("fwd_bypass_unit: REG_W out of range");
      end
   endgenerate

   // per-operand source numbers and file words, index 0 = A (rs), 1 = B (rt)
   logic [REG_W-1:0]  src_num [NOP];
   logic [DATA_W-1:0] rf_word [NOP];
   logic [DATA_W-1:0] y_word  [NOP];
   fwd_sel_e          sel_v   [NOP];
   logic              exm_hit [NOP];
   logic              wbk_hit [NOP];

   assign src_num[0] = ex_src_rs;
   assign src_num[1] = ex_src_rt;
   assign rf_word[0] = rf_word_a;
   assign rf_word[1] = rf_word_b;

   generate
      for (genvar k = 0; k < NOP; k++) begin : g_opnd
         fwd_hit_cmp #(
            .REG_W     (REG_W),
            .EXCL_ZERO (EXCL_ZERO)
         ) u_exm_cmp (
            .src_num (src_num[k]),
            .dst_num (exm_dst),
            .dst_wen (exm_wen),
            .hit     (exm_hit[k])
         );

         fwd_hit_cmp #(
            .REG_W     (REG_W),
            .EXCL_ZERO (EXCL_ZERO)
         ) u_wbk_cmp (
            .src_num (src_num[k]),
            .dst_num (wbk_dst),
            .dst_wen (wbk_wen),
            .hit     (wbk_hit[k])
         );

         fwd_sel_arb u_arb (
            .exm_hit (exm_hit[k]),
            .wbk_hit (wbk_hit[k]),
            .sel     (sel_v[k])
         );

         fwd_opnd_mux #(
            .DATA_W (DATA_W)
         ) u_mux (
            .sel      (sel_v[k]),
            .rf_word  (rf_word[k]),
            .exm_word (exm_result),
            .wbk_word (wbk_value),
            .y        (y_word[k])
         );
      end
   endgenerate

   assign sel_a  = sel_v[0];
   assign sel_b  = sel_v[1];
   assign opnd_a = y_word[0];
   assign opnd_b = y_word[1];

endmodule

// File: tb/fwd_bypass_unit_tb_top.sv
`timescale 1ns/1ps
module fwd_bypass_unit_tb_top;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #4 clk = ~clk;   // 125 MHz

   logic [4:0]  ex_src_rs, ex_src_rt, exm_dst, wbk_dst;
   logic        exm_wen, wbk_wen;
   logic [31:0] rf_word_a, rf_word_b, exm_result, wbk_value;
   logic [1:0]  sel_a, sel_b;
   logic [31:0] opnd_a, opnd_b;

   fwd_bypass_unit dut_i (
      .ex_src_rs  (ex_src_rs),
      .ex_src_rt  (ex_src_rt),
      .exm_dst    (exm_dst),
      .exm_wen    (exm_wen),
      .wbk_dst    (wbk_dst),
      .wbk_wen    (wbk_wen),
      .rf_word_a  (rf_word_a),
      .rf_word_b  (rf_word_b),
      .exm_result (exm_result),
      .wbk_value  (wbk_value),
      .sel_a      (sel_a),
      .sel_b      (sel_b),
      .opnd_a     (opnd_a),
      .opnd_b     (opnd_b)
   );

   int n_vec = 0;
   int n_bad = 0;
   int cyc   = 0;
   bit done  = 1'b0;

   // behavioural reference: 2 = exe/mem, 1 = write-back, 0 = file
   function automatic int ref_src(int src, int ed, bit ew, int wd, bit ww);
      if (ew && ed != 0 && ed == src) return 2;
      if (ww && wd != 0 && wd == src) return 1;
      return 0;
   endfunction

   function automatic string req_of(int src, int ed, bit ew, int wd, bit ww, int r);
      if (r == 2) return (ww && wd != 0 && wd == src) ? "R4" : "R2";
      if (r == 1) return (ed == src && ed != 0 && !ew) ? "R6" : "R3";
      if ((ed == src && ed == 0 && ew) || (wd == src && wd == 0 && ww)) return "R5";
      if ((ed == src && !ew) || (wd == src && !ww)) return "R6";
      return "R1";
   endfunction

   function automatic logic [31:0] pick(int r, logic [31:0] rf);
      if (r == 2) return exm_result;
      if (r == 1) return wbk_value;
      return rf;
   endfunction

   task automatic check_opnd(string nm, string lbl, int src,
                             logic [1:0] s_got, logic [31:0] d_got, logic [31:0] rf);
      int r;
      logic [1:0] s_exp;
      logic [31:0] d_exp;
      string rq;
      r = ref_src(src, int'(exm_dst), exm_wen, int'(wbk_dst), wbk_wen);
      rq = req_of(src, int'(exm_dst), exm_wen, int'(wbk_dst), wbk_wen, r);
      s_exp = (r == 2) ? 2'b10 : (r == 1) ? 2'b01 : 2'b00;
      d_exp = pick(r, rf);
      if (s_got !== s_exp) begin
         n_bad++;
         $display("FAIL %s %s sel_%s [%s]: got %b expected %b", rq, "R8", nm, lbl, s_got, s_exp);
      end
      if (d_got !== d_exp) begin
         n_bad++;
         $display("FAIL %s opnd_%s [%s]: got %h expected %h", rq, nm, lbl, d_got, d_exp);
      end
      if (s_got === 2'b11) begin
         n_bad++;
         $display("FAIL R9 sel_%s [%s]: got 11 expected not 11", nm, lbl);
      end
   endtask

   // drive after a rising edge, sample at the next falling edge (R8: same cycle)
   task automatic apply(int rs, int rt, int ed, bit ew, int wd, bit ww, string lbl);
      @(posedge clk);
      #1;
      ex_src_rs = 5'(rs);
      ex_src_rt = 5'(rt);
      exm_dst   = 5'(ed);
      exm_wen   = ew;
      wbk_dst   = 5'(wd);
      wbk_wen   = ww;
      rf_word_a  = 32'hA0A0_0000 | 32'(n_vec);
      rf_word_b  = 32'hB0B0_0000 | 32'(n_vec);
      exm_result = 32'hE0E0_0000 | 32'(n_vec);
      wbk_value  = 32'h5050_0000 | 32'(n_vec);
      @(negedge clk);
      n_vec++;
      check_opnd("a", lbl, rs, sel_a, opnd_a, rf_word_a);
      check_opnd("b", lbl, rt, sel_b, opnd_b, rf_word_b);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      ex_src_rs = '0; ex_src_rt = '0; exm_dst = '0; wbk_dst = '0;
      exm_wen = 1'b0; wbk_wen = 1'b0;
      rf_word_a = '0; rf_word_b = '0; exm_result = '0; wbk_value = '0;
      repeat (3) @(posedge clk);
      rst_n = 1'b1;

      // R1: initial quiet state, then no match at all
      apply(0, 0, 0, 0, 0, 0, "R1 idle");
      apply(3, 4, 7, 1, 9, 1, "R1 no match");
      // R2: exe/mem forward to each operand
      apply(5, 6, 5, 1, 0, 0, "R2 A from exm");
      apply(5, 6, 6, 1, 0, 0, "R2 B from exm");
      // R3: write-back forward
      apply(8, 9, 0, 0, 8, 1, "R3 A from wbk");
      apply(8, 9, 0, 0, 9, 1, "R3 B from wbk");
      // R4: both stages match, exe/mem wins
      apply(12, 12, 12, 1, 12, 1, "R4 both match both opnds");
      apply(12, 13, 12, 1, 12, 1, "R4 A only");
      // R5: register zero never forwarded
      apply(0, 0, 0, 1, 0, 1, "R5 zero both");
      apply(0, 7, 0, 1, 7, 1, "R5 zero exm, B wbk");
      // R6: write enable low blocks a stage
      apply(10, 11, 10, 0, 10, 1, "R6 exm off, wbk wins");
      apply(10, 11, 10, 0, 10, 0, "R6 both off");
      apply(10, 11, 11, 1, 10, 0, "R6 wbk off");
      // R7: independent operands, A from exm and B from wbk
      apply(14, 15, 14, 1, 15, 1, "R7 split");
      apply(15, 14, 14, 1, 15, 1, "R7 swapped");
      apply(20, 20, 20, 1, 0, 0, "R7 same src");

      // mixed stimulus over a small register range to hit many matches
      for (int i = 0; i < 600; i++) begin
         apply(int'($urandom_range(0, 3)), int'($urandom_range(0, 3)),
               int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               int'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
               "R8 mixed");
      end

      finish_run();
   end

endmodule